// File: doc/BRIEF.md
# Prescaled Up-Counting Timer Time Base

This block is the time base of a general-purpose timer. A 32-bit counter counts up from zero to a software-programmed reload limit, then wraps to zero. Each wrap raises an update event and sets a sticky interrupt flag. The counter does not advance on every input tick. A programmable divider lets through one counting step per (divisor + 1) enabled input ticks.

The divisor is double-buffered. Software writes a pending copy, and the active divider takes that copy only at an update event. An update event is one of three things:
- a natural wrap;
- a software update command, which also clears the counter;
- a pulse on the external trigger-reset input, which is handled the same way as the software command.

A reload limit of zero freezes the counter. A remap control changes the counter readback so that its top bit shows the interrupt flag instead of the counter MSB.

Software reaches the block through a small flat register port. Writes take effect at the clock edge and reads are combinational.

Top module: `tbase_top`

## Requirements
- R1: The counter advances by one per (active divisor + 1) clock cycles with `tick_en` high. It holds its value while `tick_en` is low.
- R2: A write to the divisor register (address 4, bits 15:0) changes only the pending copy, and reads return that pending copy. Until the next update event, the counting rate follows the previously active divisor.
- R3: Every update event (wrap, software command, trigger reset) copies the pending divisor into the active divider and restarts the divider from zero.
- R4: On a counting step where the counter equals the nonzero reload limit, the counter becomes 0 at that edge. `upd_evt` is high during that cycle and the flag is set.
- R5: Writing a word with bit 0 set to the command register (address 2) clears the counter, sets the flag and counts as an update event.
- R6: A cycle with `trig_rst` high clears the counter, sets the flag and counts as an update event.
- R7: While the reload limit is zero, the counter neither advances nor wraps.
- R8: After reset, the divisor reads 0, the reload limit (address 5) reads 0xFFFFFFFF, and the counter (address 3), the flag (address 1, bit 0) and the remap control (address 0, bit 0) read 0.
- R9: The flag stays set until software writes a word with bit 0 clear to address 1. Writing bit 0 set there has no effect, and an update event in the same cycle as a clearing write leaves the flag set.
- R10: With remap at 0, bit 31 of the counter readback is the counter MSB. With remap at 1, bit 31 is the flag, and in both cases bits 30:0 are the counter.
- R11: A write to the reload limit applies from the next edge, with no buffering.
- R12: `irq` equals the flag at all times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Input tick stream fed to the divider |
| trig_rst | input | 1 | External trigger reset, one more update source |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 32 | Combinational register read data |
| upd_evt | output | 1 | High in a cycle whose edge applies an update event |
| irq | output | 1 | Update interrupt flag |

## Verification
The counter is driven with three divisor settings (0, 2 and back to 0), applied through a wrap, a software command and a trigger pulse. A pending divisor that took effect early or late then shows up as a wrong count after a known number of ticks.

Idle gaps with `tick_en` low separate real counting from free-running. A zero reload limit with ticks applied separates stalling from wrapping. Lowering the limit in mid-count shows whether the new limit acts at once.

Readbacks with the flag set under both remap settings tell the flag mirror apart from the counter MSB. A clearing write in the same cycle as a trigger checks that the set has priority.

// File: rtl/tbase_pkg.sv
package tbase_pkg;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
  localparam logic [ADDR_W-1:0] A_FLAG   = 3'd1;
  localparam logic [ADDR_W-1:0] A_CMD    = 3'd2;
  localparam logic [ADDR_W-1:0] A_COUNT  = 3'd3;
  localparam logic [ADDR_W-1:0] A_PSC    = 3'd4;
  localparam logic [ADDR_W-1:0] A_RELOAD = 3'd5;
endpackage

// File: rtl/tbase_presc.sv
module tbase_presc #(
  parameter int PSC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             load_evt,
  input  logic [PSC_W-1:0] psc_pre,
  output logic             cnt_tick,
  output logic [PSC_W-1:0] psc_act
);
  logic [PSC_W-1:0] div_q;

  // A step is released when the divider has seen psc_act+1 ticks.
  function automatic logic last_tick(logic [PSC_W-1:0] div, logic [PSC_W-1:0] lim);
    return div == lim;
  endfunction

  assign cnt_tick = tick_en && last_tick(div_q, psc_act);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q   <= '0;
      psc_act <= '0;
    end else if (load_evt) begin
      div_q   <= '0;
      psc_act <= psc_pre;
    end else if (tick_en) begin
      div_q <= cnt_tick ? '0 : div_q + 1'b1;
    end
  end
endmodule

// File: rtl/tbase_counter.sv
module tbase_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_tick,
  input  logic             force_upd,
  input  logic [CNT_W-1:0] reload,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);
  function automatic logic [CNT_W-1:0] next_count(
    logic [CNT_W-1:0] cur, logic [CNT_W-1:0] lim, logic adv, logic clr);
    if (clr)                        return '0;
    else if (!adv || lim == '0)     return cur;
    else if (cur == lim)            return '0;
    else                            return cur + 1'b1;
  endfunction

  assign wrap = cnt_tick && (reload != '0) && (cnt == reload);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= next_count(cnt, reload, cnt_tick, force_upd);
  end
endmodule

// File: rtl/tbase_regs.sv
module tbase_regs
  import tbase_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int PSC_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              upd_evt,
  input  logic [CNT_W-1:0]  cnt,
  output logic [CNT_W-1:0]  rd_data,
  output logic [PSC_W-1:0]  psc_pre,
  output logic [CNT_W-1:0]  reload,
  output logic              ug_cmd,
  output logic              flag
);
  logic remap_q;

  function automatic logic [CNT_W-1:0] count_view(
    logic [CNT_W-1:0] c, logic rmp, logic f);
    logic [CNT_W-1:0] v;
    v = c;
    if (rmp) v[CNT_W-1] = f;
    return v;
  endfunction

  assign ug_cmd = wr_en && (wr_addr == A_CMD) && wr_data[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remap_q <= 1'b0;
      psc_pre <= '0;
      reload  <= '1;
    end else if (wr_en) begin
      case (wr_addr)
        A_CTRL:   remap_q <= wr_data[0];
        A_PSC:    psc_pre <= wr_data[PSC_W-1:0];
        A_RELOAD: reload  <= wr_data;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                         flag <= 1'b0;
    else if (upd_evt)                                   flag <= 1'b1;
    else if (wr_en && wr_addr == A_FLAG && !wr_data[0]) flag <= 1'b0;
  end

  always_comb begin
    case (rd_addr)
      A_CTRL:   rd_data = {{(CNT_W-1){1'b0}}, remap_q};
      A_FLAG:   rd_data = {{(CNT_W-1){1'b0}}, flag};
      A_COUNT:  rd_data = count_view(cnt, remap_q, flag);
      A_PSC:    rd_data = {{(CNT_W-PSC_W){1'b0}}, psc_pre};
      A_RELOAD: rd_data = reload;
      default:  rd_data = '0;
    endcase
  end
endmodule

// File: rtl/tbase_top.sv
module tbase_top
  import tbase_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int PSC_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              trig_rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [CNT_W-1:0]  rd_data,
  output logic              upd_evt,
  output logic              irq
);
  logic             cnt_tick;
  logic             force_upd;
  logic             wrap_evt;
  logic             ug_cmd;
  logic             flag_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] reload_q;
  logic [PSC_W-1:0] psc_pre;
  logic [PSC_W-1:0] psc_act;

  assign force_upd = ug_cmd | trig_rst;
  assign upd_evt   = force_upd | wrap_evt;
  assign irq       = flag_q;

  tbase_presc #(.PSC_W(PSC_W)) u_presc (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .load_evt(upd_evt),
    .psc_pre(psc_pre), .cnt_tick(cnt_tick), .psc_act(psc_act));

  tbase_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .cnt_tick(cnt_tick), .force_upd(force_upd),
    .reload(reload_q), .cnt(cnt_q), .wrap(wrap_evt));

  tbase_regs #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .upd_evt(upd_evt), .cnt(cnt_q),
    .rd_data(rd_data), .psc_pre(psc_pre), .reload(reload_q),
    .ug_cmd(ug_cmd), .flag(flag_q));
endmodule

// File: rtl/tbase_chk.sv
module tbase_chk #(
  parameter int CNT_W = 32,
  parameter int PSC_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cnt_tick,
  input logic             force_upd,
  input logic             wrap,
  input logic             upd_evt,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] reload,
  input logic             flag,
  input logic [PSC_W-1:0] psc_pre,
  input logic [PSC_W-1:0] psc_act
);
  a_r1_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_tick && !force_upd |=> $stable(cnt));
  a_r3_load_pending: assert property (@(posedge clk) disable iff (!rst_n)
    upd_evt |=> psc_act == $past(psc_pre));
  a_r2_active_kept: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_evt |=> $stable(psc_act));
  a_r4_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> cnt == '0 && flag);
  a_r5_forced_clear: assert property (@(posedge clk) disable iff (!rst_n)
    force_upd |=> cnt == '0 && flag);
  a_r7_zero_stall: assert property (@(posedge clk) disable iff (!rst_n)
    reload == '0 && !force_upd |=> $stable(cnt));
endmodule

bind tbase_top tbase_chk #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt_tick(cnt_tick), .force_upd(force_upd),
  .wrap(wrap_evt), .upd_evt(upd_evt), .cnt(cnt_q), .reload(reload_q),
  .flag(flag_q), .psc_pre(psc_pre), .psc_act(psc_act));

// File: tb/sim_tbase_top.sv
`timescale 1ns/1ps
module sim_tbase_top;
  localparam int SEL_RD = 0, SEL_EVT = 1, SEL_IRQ = 2;
  typedef struct { int sel; logic [31:0] exp; string tag; } item_t;

  logic clk = 0, rst_n = 0, tick_en = 0, trig_rst = 0, wr_en = 0;
  logic [2:0] wr_addr = 0, rd_addr = 0;
  logic [31:0] wr_data = 0, rd_data;
  logic upd_evt, irq;
  item_t q[$];
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  tbase_top u0 (.clk(clk), .rst_n(rst_n), .tick_en(tick_en), .trig_rst(trig_rst),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .upd_evt(upd_evt), .irq(irq));

  // Expected count after k enabled ticks since an update, divisor p, limit a.
  function automatic logic [31:0] model_cnt(int k, int p, int a);
    return (k / (p + 1)) % (a + 1);
  endfunction

  // Monitor: pops the scoreboard just after each falling edge.
  always @(negedge clk) begin
    #1;
    while (q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = q.pop_front();
      act = (it.sel == SEL_RD) ? rd_data : (it.sel == SEL_EVT) ? {31'd0, upd_evt} : {31'd0, irq};
      n_cmp++;
      if (act !== it.exp) begin
        n_bad++;
        $display("FAIL %s: actual 0x%08h expected 0x%08h", it.tag, act, it.exp);
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic run(input int n);
    tick_en = 1;
    repeat (n) @(negedge clk);
    tick_en = 0;
  endtask

  task automatic expect_item(input int sel, input logic [2:0] a, input logic [31:0] e,
                             input string tag);
    item_t it;
    @(negedge clk);
    rd_addr = a;
    it.sel = sel; it.exp = e; it.tag = tag;
    q.push_back(it);
    #2;
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R8 reset state, R12 irq follows flag
    expect_item(SEL_RD, 3'd4, 32'h0, "R8 divisor");
    expect_item(SEL_RD, 3'd5, 32'hFFFF_FFFF, "R8 reload");
    expect_item(SEL_RD, 3'd3, 32'h0, "R8 count");
    expect_item(SEL_RD, 3'd1, 32'h0, "R8 flag");
    expect_item(SEL_RD, 3'd0, 32'h0, "R8 remap");
    expect_item(SEL_IRQ, 3'd0, 32'h0, "R12 irq idle");

    // R11 limit applies at once; R1 rate with divisor 0
    wr(3'd5, 32'd4);
    run(3);
    expect_item(SEL_RD, 3'd3, model_cnt(3, 0, 4), "R1 count divisor 0");
    repeat (3) @(negedge clk);
    expect_item(SEL_RD, 3'd3, 32'd3, "R1 hold with tick_en low");
    run(1);
    expect_item(SEL_EVT, 3'd3, 32'd0, "R4 no event without tick");
    @(negedge clk);
    tick_en = 1;
    begin
      item_t it;
      it.sel = SEL_EVT; it.exp = 1; it.tag = "R4 event on wrap step";
      q.push_back(it);
    end
    #2;
    @(negedge clk);
    tick_en = 0;
    expect_item(SEL_RD, 3'd3, 32'd0, "R4 count wraps to 0");
    expect_item(SEL_RD, 3'd1, 32'd1, "R4 flag set");
    expect_item(SEL_IRQ, 3'd0, 32'd1, "R12 irq set");

    // R9 sticky flag
    wr(3'd1, 32'd1);
    expect_item(SEL_RD, 3'd1, 32'd1, "R9 writing 1 ignored");
    wr(3'd1, 32'd0);
    expect_item(SEL_RD, 3'd1, 32'd0, "R9 clear by writing 0");

    // R2 pending divisor
    wr(3'd4, 32'd2);
    expect_item(SEL_RD, 3'd4, 32'd2, "R2 read pending divisor");
    run(3);
    expect_item(SEL_RD, 3'd3, 32'd3, "R2 old divisor still active");

    // R5 software update, R3 divisor loaded
    wr(3'd2, 32'd1);
    expect_item(SEL_RD, 3'd3, 32'd0, "R5 count cleared");
    expect_item(SEL_RD, 3'd1, 32'd1, "R5 flag set");
    run(3);
    expect_item(SEL_RD, 3'd3, model_cnt(3, 2, 4), "R3 divisor 2 after 3 ticks");
    run(2);
    expect_item(SEL_RD, 3'd3, model_cnt(5, 2, 4), "R3 divisor 2 after 5 ticks");
    run(1);
    expect_item(SEL_RD, 3'd3, model_cnt(6, 2, 4), "R3 divisor 2 after 6 ticks");

    // R6 trigger reset loads pending divisor 0
    wr(3'd1, 32'd0);
    wr(3'd4, 32'd0);
    trig_rst = 1;
    @(negedge clk);
    trig_rst = 0;
    expect_item(SEL_RD, 3'd3, 32'd0, "R6 count cleared");
    expect_item(SEL_RD, 3'd1, 32'd1, "R6 flag set");
    run(2);
    expect_item(SEL_RD, 3'd3, model_cnt(2, 0, 4), "R3 trigger loads divisor");

    // R7 zero limit stalls
    wr(3'd1, 32'd0);
    wr(3'd5, 32'd0);
    run(6);
    expect_item(SEL_RD, 3'd3, 32'd2, "R7 count frozen");
    expect_item(SEL_RD, 3'd1, 32'd0, "R7 no wrap flag");

    // R11 new limit used from next step
    wr(3'd5, 32'd3);
    run(1);
    expect_item(SEL_RD, 3'd3, 32'd3, "R11 count reaches new limit");
    run(1);
    expect_item(SEL_RD, 3'd3, 32'd0, "R11 wrap at new limit");
    expect_item(SEL_RD, 3'd1, 32'd1, "R11 flag on wrap");

    // R10 remap of readback bit 31
    run(2);
    wr(3'd0, 32'd1);
    expect_item(SEL_RD, 3'd3, 32'h8000_0002, "R10 remap shows flag");
    wr(3'd0, 32'd0);
    expect_item(SEL_RD, 3'd3, 32'h0000_0002, "R10 no remap shows MSB");
    wr(3'd1, 32'd0);
    wr(3'd0, 32'd1);
    expect_item(SEL_RD, 3'd3, 32'h0000_0002, "R10 remap flag clear");

    // R9 set wins over clear in the same cycle
    wr_en = 1; wr_addr = 3'd1; wr_data = 32'd0; trig_rst = 1;
    @(negedge clk);
    wr_en = 0; trig_rst = 0;
    expect_item(SEL_RD, 3'd1, 32'd1, "R9 set has priority");
    expect_item(SEL_IRQ, 3'd0, 32'd1, "R12 irq after trigger");

    @(negedge clk);
    #3;
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule